// File: doc/BRIEF.md
# Triangular-Window Sample Smoother

This block smooths a stream of signed 14-bit samples with a triangular (Bartlett) window and produces one result per accepted sample, with no decimation. The triangle comes from two running averages in series, each taking the mean of the last N samples, where N = 2^M. Each average is a running sum divided by an arithmetic right shift. The frequency response is therefore the square of one N-tap average's response.

M comes from a 4-bit tap field. A 3-bit range code selects the full-scale range, and the narrower ranges need more smoothing, so they impose a minimum M. A change to either field restarts the filter from empty history. No result is flagged valid until both averages hold a full window of samples taken under the new setting.

Top module: `bartlett_avg_filter`

## Requirements
- R1: After reset, `out_valid` is low and stays low until samples are accepted.
- R2: The window length per stage is N = 2^M, where M is `tap_log`. Field values above 7 act as 7, so N is at most 128.
- R3: Some range codes raise a smaller M to a floor. Code 3'b010 (half range) gives M ≥ 2. Code 3'b001 (quarter range) gives M ≥ 4. Code 3'b100 (widest range) and every other code impose no floor.
- R4: With an effective M of 0, each accepted sample appears unchanged on `out_sample`.
- R5: For accepted sample x[k], the result is y[k] = floor(Σ_{j<N} floor(Σ_{i<N} x[k−j−i] / N) / N). It appears with `out_valid` high for one cycle, two clock cycles after the sample's `in_valid` cycle.
- R6: After a configuration change, `out_valid` stays low for the first 2N−2 accepted samples. Every later accepted sample produces one valid result.
- R7: A cycle in which `tap_log` or `range_sel` differs from its value in the previous cycle clears all history. A sample offered in that cycle is ignored, and a result still in flight is dropped. This holds even when the effective N is unchanged.
- R8: A constant input settles to exactly that constant. This includes −8192 and +8191 with N = 128, so the sums never overflow.
- R9: Cycles with `in_valid` low neither advance the filter nor raise `out_valid`. Gaps in the input do not change later results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 14 | Signed two's-complement input sample |
| tap_log | input | 4 | Requested M (window length 2^M per stage) |
| range_sel | input | 3 | Range code that sets the minimum M |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 14 | Signed smoothed result |

## Verification
- An M = 0 stream holding both extreme codes shows whether the pass-through keeps full width and sign.
- A single impulse among zeros traces the triangular response shape, which would reveal a single average or a wrong divisor.
- Pseudo-random signed data at N = 4 tests both floored divisions against a model. Long constant runs at N = 128 at both extremes expose accumulator overflow and rounding drift.
- Configuration changes tie to the warm-up count: a change with an unchanged effective N, a change during an in-flight result, and gaps in the input show whether history really clears, or is wrongly kept or advanced.

// File: rtl/bartlett_pkg.sv
package bartlett_pkg;

   localparam logic [2:0] RANGE_WIDE    = 3'b100;
   localparam logic [2:0] RANGE_HALF    = 3'b010;
   localparam logic [2:0] RANGE_QUARTER = 3'b001;

   localparam int unsigned HALF_MIN_LOG    = 2;
   localparam int unsigned QUARTER_MIN_LOG = 4;

   // Smallest window exponent permitted for a range code.
   function automatic int unsigned range_floor(logic [2:0] code);
      case (code)
         RANGE_HALF:    return HALF_MIN_LOG;
         RANGE_QUARTER: return QUARTER_MIN_LOG;
         default:       return 0;
      endcase
   endfunction

endpackage

// File: rtl/tap_limiter.sv
module tap_limiter
   import bartlett_pkg::*;
#(
   parameter int TAP_W   = 4,
   parameter int MAX_LOG = 7,
   parameter int LOG_W   = 3
) (
   input  logic [TAP_W-1:0] tap_log,
   input  logic [2:0]       range_sel,
   output logic [LOG_W-1:0] eff_log
);

   logic [LOG_W-1:0] clamped;
   logic [LOG_W-1:0] floor_log;

   always_comb begin
      clamped   = (tap_log > TAP_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : LOG_W'(tap_log);
      floor_log = LOG_W'(range_floor(range_sel));
      eff_log   = (clamped < floor_log) ? floor_log : clamped;
   end

endmodule

// File: rtl/boxcar_stage.sv
module boxcar_stage #(
   parameter int DATA_W  = 14,
   parameter int MAX_LOG = 7,
   parameter int LOG_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic [LOG_W-1:0]         shift,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);

   localparam int DEPTH  = 1 << MAX_LOG;
   localparam int PTR_W  = MAX_LOG;
   localparam int FILL_W = MAX_LOG + 1;
   localparam int SUM_W  = DATA_W + MAX_LOG;

   logic signed [DATA_W-1:0] line [DEPTH];
   logic [PTR_W-1:0]         wr_ptr;
   logic [FILL_W-1:0]        fill;
   logic signed [SUM_W-1:0]  acc;

   logic [FILL_W-1:0]        n_taps;
   logic [PTR_W-1:0]         rd_ptr;
   logic signed [DATA_W-1:0] oldest;
   logic signed [SUM_W-1:0]  acc_next;
   logic                     take;

   always_comb begin
      take     = in_valid && !clear;
      n_taps   = FILL_W'(1) << shift;
      rd_ptr   = wr_ptr - n_taps[PTR_W-1:0];
      // Until the window is full the departing sample counts as zero.
      oldest   = (fill >= n_taps) ? line[rd_ptr] : '0;
      acc_next = acc + SUM_W'(in_data) - SUM_W'(oldest);
   end

   always_ff @(posedge clk) begin
      if (take) line[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         fill      <= '0;
         acc       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (clear) begin
         wr_ptr    <= '0;
         fill      <= '0;
         acc       <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= take;
         if (take) begin
            wr_ptr   <= wr_ptr + PTR_W'(1);
            acc      <= acc_next;
            out_data <= DATA_W'(acc_next >>> shift);
            if (fill < n_taps) fill <= fill + FILL_W'(1);
         end
      end
   end

endmodule

// File: rtl/bartlett_avg_filter.sv
module bartlett_avg_filter #(
   parameter int DATA_W  = 14,
   parameter int TAP_W   = 4,
   parameter int MAX_LOG = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic [TAP_W-1:0]         tap_log,
   input  logic [2:0]               range_sel,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_sample
);

   localparam int NUM_STAGES = 2;
   localparam int LOG_W      = $clog2(MAX_LOG + 1);
   localparam int CNT_W      = MAX_LOG + 2;

   generate
      if (MAX_LOG < 4) begin : g_bad_max_log
         $error("MAX_LOG must reach the quarter-range floor of 4");
      end
      if (((1 << TAP_W) - 1) < MAX_LOG) begin : g_bad_tap_w
         $error("TAP_W too narrow to express MAX_LOG");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [TAP_W-1:0]  tap_q;
   logic [2:0]        range_q;
   logic              cfg_change;
   logic              accept;
   logic [LOG_W-1:0]  eff_log;
   logic [CNT_W-1:0]  seen;
   logic [CNT_W-1:0]  n_taps;
   logic [CNT_W-1:0]  need;
   logic              warm_in;
   logic [NUM_STAGES-1:0] warm_pipe;

   tap_limiter #(.TAP_W(TAP_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_limit (
      .tap_log   (tap_log),
      .range_sel (range_sel),
      .eff_log   (eff_log)
   );

   always_comb begin
      cfg_change = (tap_log != tap_q) || (range_sel != range_q);
      accept     = in_valid && !cfg_change;
      n_taps     = CNT_W'(1) << eff_log;
      need       = CNT_W'(NUM_STAGES) * (n_taps - CNT_W'(1));
      warm_in    = (seen >= need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q     <= '0;
         range_q   <= '0;
         seen      <= '0;
         warm_pipe <= '0;
      end else begin
         tap_q   <= tap_log;
         range_q <= range_sel;
         if (cfg_change) begin
            seen      <= '0;
            warm_pipe <= '0;
         end else begin
            warm_pipe <= {warm_pipe[NUM_STAGES-2:0], accept && warm_in};
            if (accept && (seen != '1)) seen <= seen + CNT_W'(1);
         end
      end
   end

   logic                     stg_v [NUM_STAGES+1];
   logic signed [DATA_W-1:0] stg_d [NUM_STAGES+1];

   assign stg_v[0] = accept;
   assign stg_d[0] = in_sample;

   generate
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
         boxcar_stage #(.DATA_W(DATA_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_box (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (cfg_change),
            .in_valid  (stg_v[s]),
            .in_data   (stg_d[s]),
            .shift     (eff_log),
            .out_valid (stg_v[s+1]),
            .out_data  (stg_d[s+1])
         );
      end
   endgenerate

   assign out_valid  = stg_v[NUM_STAGES] && warm_pipe[NUM_STAGES-1];
   assign out_sample = stg_d[NUM_STAGES];

endmodule

// File: rtl/bartlett_avg_filter_chk.sv
module bartlett_avg_filter_chk
   import bartlett_pkg::*;
#(
   parameter int DATA_W  = 14,
   parameter int TAP_W   = 4,
   parameter int MAX_LOG = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] in_sample,
   input logic [TAP_W-1:0]         tap_log,
   input logic [2:0]               range_sel,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_sample
);

   logic [TAP_W-1:0] tap_prev;
   logic [2:0]       range_prev;
   logic [8:0]       n_seen;
   logic             chg;
   int unsigned      m_prev;

   always_comb begin
      chg    = (tap_log != tap_prev) || (range_sel != range_prev);
      m_prev = (int'(tap_prev) > MAX_LOG) ? MAX_LOG : int'(tap_prev);
      if (m_prev < range_floor(range_prev)) m_prev = range_floor(range_prev);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_prev   <= '0;
         range_prev <= '0;
         n_seen     <= '0;
      end else begin
         tap_prev   <= tap_log;
         range_prev <= range_sel;
         if (chg) n_seen <= '0;
         else if (in_valid && n_seen != '1) n_seen <= n_seen + 9'd1;
      end
   end

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2)); // R5

   AST_WARMUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(n_seen) >= 2 * (1 << m_prev) - 1)); // R6

   AST_CHANGE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !out_valid); // R7

   AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tap_prev == '0 && range_prev == RANGE_WIDE)
         |-> out_sample == $past(in_sample, 2)); // R4

endmodule

bind bartlett_avg_filter bartlett_avg_filter_chk #(
   .DATA_W(DATA_W), .TAP_W(TAP_W), .MAX_LOG(MAX_LOG)
) u_chk (.*);

// File: tb/bartlett_avg_filter_bench.sv
`timescale 1ns/1ps
module bartlett_avg_filter_bench;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic signed [13:0] in_sample = '0;
   logic [3:0]        tap_log = '0;
   logic [2:0]        range_sel = 3'b100;
   logic              out_valid;
   logic signed [13:0] out_sample;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   int hist [0:1023];
   int nh = 0;
   int cur_tap = 0;
   int cur_rng = 4;
   logic [31:0] seed = 32'h1234_5678;

   always #2.5 clk = ~clk;

   bartlett_avg_filter u_bartlett_avg_filter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .tap_log(tap_log), .range_sel(range_sel),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic int eff_m(int tap, int rng);
      int m = (tap > 7) ? 7 : tap;
      if (rng == 2 && m < 2) m = 2;
      if (rng == 1 && m < 4) m = 4;
      return m;
   endfunction

   function automatic int next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'({18'd0, seed[23:10]}) - 8192;
   endfunction

   task automatic check_val(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Starts and ends at a negedge; checks the result two cycles later.
   task automatic send(int x, string req);
      int m, n, k, y, s;
      in_valid  = 1'b1;
      in_sample = 14'(x);
      hist[nh] = x;
      nh++;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      m = eff_m(cur_tap, cur_rng);
      n = 1 << m;
      k = nh - 1;
      if (k < 2 * n - 2) begin
         check_val(req, "out_valid during warm-up", int'(out_valid), 0);
      end else begin
         y = 0;
         for (int j = 0; j < n; j++) begin
            s = 0;
            for (int i = 0; i < n; i++) s += hist[k - j - i];
            y += (s >>> m);
         end
         y = y >>> m;
         check_val(req, "out_valid", int'(out_valid), 1);
         check_val(req, "out_sample", int'(out_sample), y);
      end
   endtask

   task automatic set_cfg(int tap, int rng);
      tap_log   = 4'(tap);
      range_sel = 3'(rng);
      in_valid  = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cur_tap = tap;
      cur_rng = rng;
      nh = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_val("R1", "out_valid after reset", int'(out_valid), 0);
      @(posedge clk);
      @(negedge clk);
      check_val("R1", "out_valid idle", int'(out_valid), 0);
   endtask

   task automatic t_passthrough();
      set_cfg(0, 4);
      send(0, "R4"); send(1, "R4"); send(-1, "R4");
      send(8191, "R4"); send(-8192, "R4"); send(1234, "R4");
   endtask

   task automatic t_impulse();
      set_cfg(3, 4);
      for (int i = 0; i < 14; i++) send(0, "R5");
      send(4096, "R5");
      for (int i = 0; i < 18; i++) send(0, "R5");
   endtask

   task automatic t_random();
      set_cfg(2, 4);
      for (int i = 0; i < 30; i++) send(next_rand(), "R5");
   endtask

   task automatic t_ranges();
      set_cfg(0, 2);
      for (int i = 0; i < 10; i++) send(next_rand(), "R3");
      set_cfg(1, 1);
      for (int i = 0; i < 36; i++) send(next_rand(), "R3");
      set_cfg(1, 7);
      for (int i = 0; i < 6; i++) send(next_rand(), "R3");
   endtask

   task automatic t_clamp();
      set_cfg(12, 4);
      for (int i = 0; i < 258; i++) send(-8192, "R2");
      check_val("R8", "settled low extreme", int'(out_sample), -8192);
      set_cfg(15, 4);
      for (int i = 0; i < 258; i++) send(8191, "R8");
      check_val("R8", "settled high extreme", int'(out_sample), 8191);
   endtask

   task automatic t_clear();
      set_cfg(2, 4);
      for (int i = 0; i < 9; i++) send(3000, "R7");
      // Offer one more sample, then change M while its result is in flight.
      in_valid  = 1'b1;
      in_sample = 14'(3000);
      @(posedge clk);
      @(negedge clk);
      tap_log   = 4'd1;
      in_sample = 14'(7777);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_val("R7", "in-flight result dropped", int'(out_valid), 0);
      @(posedge clk);
      @(negedge clk);
      check_val("R7", "ignored sample gives no result", int'(out_valid), 0);
      cur_tap = 1;
      nh = 0;
      for (int i = 0; i < 6; i++) send(-500 + 100 * i, "R7");
      // Range code change with the same effective N still clears.
      set_cfg(2, 4);
      for (int i = 0; i < 8; i++) send(next_rand(), "R6");
      set_cfg(2, 2);
      for (int i = 0; i < 8; i++) send(next_rand(), "R7");
   endtask

   task automatic t_gaps();
      set_cfg(2, 4);
      for (int i = 0; i < 8; i++) send(next_rand(), "R9");
      for (int i = 0; i < 10; i++) begin
         @(posedge clk);
         @(negedge clk);
         check_val("R9", "out_valid in gap", int'(out_valid), 0);
      end
      for (int i = 0; i < 6; i++) send(next_rand(), "R9");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_passthrough();
      t_impulse();
      t_random();
      t_ranges();
      t_clamp();
      t_clear();
      t_gaps();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule